// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the eight-byte register window that host software uses to steer one bus-master DMA channel of a disk controller. Software sets up the transfer direction and the address of the descriptor table, then sets a run bit. The block passes run, direction and table address to a separate DMA engine. It also collects the engine's end-of-table, error and device-interrupt events into a status byte. A level interrupt output is raised from that status byte.

The status byte combines three kinds of bit. There is an active flag that only hardware can change. There are error and interrupt flags that hardware sets and software clears by writing one. There are two per-drive "DMA capable" flags that software reads and writes freely. Software treats a transfer as having finished cleanly when the low three status bits read 100b: interrupt set, no error, engine idle. The register bus is one byte wide. Reads are combinational on the addressed byte. A write takes effect at the next clock edge.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00, and `irq`, `eng_run` and `eng_to_mem` are 0.
- R2: At offset 0, bit 0 is the run control. Writing it as 1 while it reads 0 sets the active flag (status bit 0) and `eng_run` from the next cycle. Writing it as 0 clears the run bit, the active flag and `eng_run`.
- R3: At offset 0, bit 3 is the direction bit (1 = engine writes memory). It drives `eng_to_mem`. A command write changes it only while the channel is not active. Offset 0 reads back bits 0 and 3, and all other bits read 0.
- R4: An `eng_done` pulse clears the active flag and `eng_run`, and the run bit still reads 1. Writing run as 1 again while it already reads 1 does not restart the engine.
- R5: An `eng_err` pulse sets status bit 1 and clears the active flag and `eng_run`.
- R6: An `eng_intr` pulse sets status bit 2. `irq` equals status bit 2. After `eng_done` and `eng_intr`, status bits 2:0 read 100b.
- R7: A write to offset 2 clears bit 1 or bit 2 where the written bit is 1, and leaves it unchanged where the written bit is 0. An engine event in the same cycle wins over the clear.
- R8: Status bits 5 and 6 are plain read/write flags. Writes to status bit 0 are ignored. Status bits 3, 4 and 7 always read 0.
- R9: Offsets 4 to 7 hold the descriptor table address, least significant byte first. Bits 1:0 always read 0 and are 0 on `eng_table_base`.
- R10: Offsets 1 and 3 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed byte |
| reg_addr | input | 3 | Byte offset in the window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed byte |
| eng_done | input | 1 | Engine reached end of descriptor table |
| eng_err | input | 1 | Engine reports a transfer error |
| eng_intr | input | 1 | Device interrupt for this channel |
| eng_run | output | 1 | Engine run enable |
| eng_to_mem | output | 1 | Direction: 1 = engine writes memory |
| eng_table_base | output | 32 | Descriptor table address, dword aligned |
| irq | output | 1 | Interrupt request, follows status bit 2 |

## Verification
The embedded assertions check the following on every cycle:
- A run rising-edge write starts the channel.
- End-of-table and error events stop it.
- The direction bit holds still during an active transfer.
- Each flag event sets its flag.
- Write-one clears take effect unless an event collides with them.
- The drive-capable flags take the written value.

Some behaviour can only be shown by the bench's scenarios:
- The read-back layout of each byte, including reserved and vendor bytes reading zero.
- The refusal to restart from an already-set run bit.
- The 100b completion pattern.
- The forced zero in the low address bits as seen at the port.

// File: rtl/dma_chan_pkg.sv
// Shared constants for the DMA channel register window.
// Assumes a byte-wide register bus with a 3-bit offset.
package dma_chan_pkg;
    localparam int BYTE_W   = 8;
    localparam int OFS_W    = 3;

    // Byte offsets within the window
    localparam logic [OFS_W-1:0] OFS_CMD  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_VND1 = 3'd1;
    localparam logic [OFS_W-1:0] OFS_STAT = 3'd2;
    localparam logic [OFS_W-1:0] OFS_VND3 = 3'd3;
    localparam logic [OFS_W-1:0] OFS_PTR  = 3'd4;

    // Command bit positions
    localparam int CMD_RUN_B = 0;
    localparam int CMD_DIR_B = 3;

    // Status bit positions
    localparam int ST_ACT_B  = 0;
    localparam int ST_ERR_B  = 1;
    localparam int ST_INT_B  = 2;
    localparam int ST_CAP0_B = 5;
    localparam int ST_CAP1_B = 6;
endpackage

// File: rtl/dma_cmd_ctl.sv
// Command control: run bit, direction bit and the active flag.
// Assumes single-cycle event pulses from the engine; a run rising
// write wins over a same-cycle stop event (the channel was idle then).
module dma_cmd_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic wr_run,
    input  logic wr_dir,
    input  logic stop_evt,
    output logic run_q,
    output logic dir_q,
    output logic active_q
);
    logic start_req;
    assign start_req = cmd_wr && wr_run && !run_q;

    // Run and direction bits, direction frozen while active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            dir_q <= 1'b0;
        end else if (cmd_wr) begin
            run_q <= wr_run;
            if (!active_q) dir_q <= wr_dir;
        end
    end

    // Active flag: set on run rising write, cleared by stop write or engine stop
    always_ff @(posedge clk) begin
        if (!rst_n)                   active_q <= 1'b0;
        else if (start_req)           active_q <= 1'b1;
        else if (cmd_wr && !wr_run)   active_q <= 1'b0;
        else if (stop_evt)            active_q <= 1'b0;
    end

    // R2
    run_rise_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> active_q);
    // R4
    stop_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && run_q) |=> !active_q);
    // R3
    dir_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |=> $stable(dir_q));
endmodule

// File: rtl/dma_stat_ctl.sv
// Status flags: sticky error and interrupt with write-one-to-clear,
// plus two software read/write drive-capable flags.
// Assumes a same-cycle event beats a software clear.
module dma_stat_ctl #(
    parameter int NUM_CAP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stat_wr,
    input  logic               clr_err,
    input  logic               clr_int,
    input  logic [NUM_CAP-1:0] wr_cap,
    input  logic               err_evt,
    input  logic               int_evt,
    output logic               err_q,
    output logic               int_q,
    output logic [NUM_CAP-1:0] cap_q
);
    // Error flag: set by engine, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n)                    err_q <= 1'b0;
        else if (err_evt)              err_q <= 1'b1;
        else if (stat_wr && clr_err)   err_q <= 1'b0;
    end

    // Interrupt flag: set by device event, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n)                    int_q <= 1'b0;
        else if (int_evt)              int_q <= 1'b1;
        else if (stat_wr && clr_int)   int_q <= 1'b0;
    end

    // Drive-capable flags, one per drive
    for (genvar g = 0; g < NUM_CAP; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n)       cap_q[g] <= 1'b0;
            else if (stat_wr) cap_q[g] <= wr_cap[g];
        end
    end

    // R5
    err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> err_q);
    // R6
    int_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_evt |=> int_q);
    // R7
    err_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && clr_err && !err_evt) |=> !err_q);
    // R7
    int_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !clr_int && int_q) |=> int_q);
    // R8
    cap_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (cap_q == $past(wr_cap)));
endmodule

// File: rtl/dma_table_ptr.sv
// Descriptor table address register, written one byte at a time.
// Assumes little-endian byte order; the low two bits are not stored.
module dma_table_ptr
    import dma_chan_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic [1:0]        byte_sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr_q
);
    localparam int NBYTES = PTR_W / BYTE_W;

    // Byte lanes; lane 0 keeps only bits 7:2
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        if (b == 0) begin : g_low
            logic [BYTE_W-1:2] hi_bits;
            // Low lane storage, alignment bits tied off
            always_ff @(posedge clk) begin
                if (!rst_n)                         hi_bits <= '0;
                else if (ptr_wr && byte_sel == 2'(b)) hi_bits <= wdata[BYTE_W-1:2];
            end
            assign ptr_q[BYTE_W-1:0] = {hi_bits, 2'b00};
        end else begin : g_up
            logic [BYTE_W-1:0] lane;
            // Upper lane storage
            always_ff @(posedge clk) begin
                if (!rst_n)                         lane <= '0;
                else if (ptr_wr && byte_sel == 2'(b)) lane <= wdata;
            end
            assign ptr_q[b*BYTE_W +: BYTE_W] = lane;
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
// Top of the DMA channel register window: decodes the byte offset,
// routes writes to the command, status and pointer parts, and builds
// the read data. Assumes reads have no side effects.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              eng_intr,
    output logic              eng_run,
    output logic              eng_to_mem,
    output logic [PTR_W-1:0]  eng_table_base,
    output logic              irq
);
    logic cmd_wr, stat_wr, ptr_wr;
    logic run_q, dir_q, active_q, err_q, int_q;
    logic [1:0] cap_q;
    logic [PTR_W-1:0] ptr_q;

    // Write decode per register
    assign cmd_wr  = reg_wr && (reg_addr == OFS_CMD);
    assign stat_wr = reg_wr && (reg_addr == OFS_STAT);
    assign ptr_wr  = reg_wr && reg_addr[2];

    dma_cmd_ctl u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .wr_run   (reg_wdata[CMD_RUN_B]),
        .wr_dir   (reg_wdata[CMD_DIR_B]),
        .stop_evt (eng_done || eng_err),
        .run_q    (run_q),
        .dir_q    (dir_q),
        .active_q (active_q)
    );

    dma_stat_ctl #(.NUM_CAP(2)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_wr (stat_wr),
        .clr_err (reg_wdata[ST_ERR_B]),
        .clr_int (reg_wdata[ST_INT_B]),
        .wr_cap  (reg_wdata[ST_CAP1_B:ST_CAP0_B]),
        .err_evt (eng_err),
        .int_evt (eng_intr),
        .err_q   (err_q),
        .int_q   (int_q),
        .cap_q   (cap_q)
    );

    dma_table_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_wr   (ptr_wr),
        .byte_sel (reg_addr[1:0]),
        .wdata    (reg_wdata),
        .ptr_q    (ptr_q)
    );

    // Engine-facing outputs
    assign eng_run        = active_q;
    assign eng_to_mem     = dir_q;
    assign eng_table_base = ptr_q;
    assign irq            = int_q;

    // Read data assembly for the addressed byte
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD: begin
                reg_rdata[CMD_RUN_B] = run_q;
                reg_rdata[CMD_DIR_B] = dir_q;
            end
            OFS_STAT: begin
                reg_rdata[ST_ACT_B]  = active_q;
                reg_rdata[ST_ERR_B]  = err_q;
                reg_rdata[ST_INT_B]  = int_q;
                reg_rdata[ST_CAP0_B] = cap_q[0];
                reg_rdata[ST_CAP1_B] = cap_q[1];
            end
            OFS_VND1, OFS_VND3: reg_rdata = '0;
            default: reg_rdata = ptr_q[reg_addr[1:0]*BYTE_W +: BYTE_W];
        endcase
    end

    // R9
    ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && reg_addr[1:0] == 2'd0) |=> (eng_table_base[1:0] == 2'b00));
    // R6
    irq_follows_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_intr |=> irq);
endmodule

// File: tb/dma_chan_regs_test.sv
// Bench for the DMA channel register window: a vector table walked by
// one loop, then directed tests for restart, direction and reset.
module dma_chan_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        eng_done = 1'b0, eng_err = 1'b0, eng_intr = 1'b0;
    logic        eng_run, eng_to_mem, irq;
    logic [31:0] eng_table_base;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    dma_chan_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_done(eng_done),
        .eng_err(eng_err), .eng_intr(eng_intr), .eng_run(eng_run),
        .eng_to_mem(eng_to_mem), .eng_table_base(eng_table_base), .irq(irq)
    );

    typedef struct packed {
        logic       wr;
        logic [2:0] addr;
        logic [7:0] wdata;
        logic       done;
        logic       err;
        logic       intr;
        logic [2:0] chk_addr;
        logic [7:0] exp;
        logic       exp_irq;
        logic       exp_run;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd0, 8'h08, 1'b0, 1'b0, 1'b0, 3'd0, 8'h08, 1'b0, 1'b0, 4'd3},  // R3 dir set idle
        '{1'b1, 3'd0, 8'h09, 1'b0, 1'b0, 1'b0, 3'd2, 8'h01, 1'b0, 1'b1, 4'd2},  // R2 start
        '{1'b1, 3'd0, 8'h01, 1'b0, 1'b0, 1'b0, 3'd0, 8'h09, 1'b0, 1'b1, 4'd3},  // R3 dir frozen
        '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 done
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 3'd2, 8'h04, 1'b1, 1'b0, 4'd6},  // R6 good 100b
        '{1'b1, 3'd2, 8'h00, 1'b0, 1'b0, 1'b0, 3'd2, 8'h04, 1'b1, 1'b0, 4'd7},  // R7 write 0 keeps
        '{1'b1, 3'd2, 8'h04, 1'b0, 1'b0, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, 4'd7},  // R7 w1c
        '{1'b1, 3'd2, 8'h61, 1'b0, 1'b0, 1'b0, 3'd2, 8'h60, 1'b0, 1'b0, 4'd8},  // R8 caps, bit0 ignored
        '{1'b1, 3'd2, 8'h18, 1'b0, 1'b0, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, 4'd8},  // R8 bits 3,4 read 0
        '{1'b1, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 4'd2},  // R2 stop
        '{1'b1, 3'd0, 8'h01, 1'b0, 1'b0, 1'b0, 3'd2, 8'h01, 1'b0, 1'b1, 4'd2},  // R2 restart
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd2, 8'h02, 1'b0, 1'b0, 4'd5},  // R5 error
        '{1'b1, 3'd2, 8'h06, 1'b0, 1'b0, 1'b1, 3'd2, 8'h04, 1'b1, 1'b0, 4'd7},  // R7 event beats clear
        '{1'b1, 3'd2, 8'h04, 1'b0, 1'b0, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, 4'd7},  // R7 clear irq
        '{1'b1, 3'd4, 8'hFF, 1'b0, 1'b0, 1'b0, 3'd4, 8'hFC, 1'b0, 1'b0, 4'd9},  // R9 low bits 0
        '{1'b1, 3'd5, 8'h12, 1'b0, 1'b0, 1'b0, 3'd5, 8'h12, 1'b0, 1'b0, 4'd9},  // R9
        '{1'b1, 3'd6, 8'h34, 1'b0, 1'b0, 1'b0, 3'd6, 8'h34, 1'b0, 1'b0, 4'd9},  // R9
        '{1'b1, 3'd7, 8'h80, 1'b0, 1'b0, 1'b0, 3'd7, 8'h80, 1'b0, 1'b0, 4'd9},  // R9
        '{1'b1, 3'd1, 8'hFF, 1'b0, 1'b0, 1'b0, 3'd1, 8'h00, 1'b0, 1'b0, 4'd10}, // R10
        '{1'b1, 3'd3, 8'hFF, 1'b0, 1'b0, 1'b0, 3'd3, 8'h00, 1'b0, 1'b0, 4'd10}  // R10
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, $sformatf("rd @%0d", a), {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic write_byte(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) read_chk("R1", 3'(a), 8'h00);
        check("R1", "irq/run/dir", {29'h0, irq, eng_run, eng_to_mem}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_wr = VEC[i].wr; reg_addr = VEC[i].addr; reg_wdata = VEC[i].wdata;
            eng_done = VEC[i].done; eng_err = VEC[i].err; eng_intr = VEC[i].intr;
            @(negedge clk);
            reg_wr = 1'b0; eng_done = 1'b0; eng_err = 1'b0; eng_intr = 1'b0;
            read_chk($sformatf("R%0d", VEC[i].req), VEC[i].chk_addr, VEC[i].exp);
            check($sformatf("R%0d", VEC[i].req), "irq", {31'h0, irq}, {31'h0, VEC[i].exp_irq});
            check($sformatf("R%0d", VEC[i].req), "run", {31'h0, eng_run}, {31'h0, VEC[i].exp_run});
        end

        // R9 table address at the port
        check("R9", "table base", eng_table_base, 32'h803412FC);
        // R10 vendor writes left command and status alone
        read_chk("R10", 3'd0, 8'h01);
        read_chk("R10", 3'd2, 8'h00);

        // R4 run bit already 1: rewriting 1 does not restart
        write_byte(3'd0, 8'h01);
        read_chk("R4", 3'd2, 8'h00);
        check("R4", "run no restart", {31'h0, eng_run}, 32'h0);
        read_chk("R4", 3'd0, 8'h01);

        // R3 direction accepted while idle, drives eng_to_mem
        write_byte(3'd0, 8'h08);
        check("R3", "to_mem", {31'h0, eng_to_mem}, 32'h1);
        read_chk("R3", 3'd0, 8'h08);

        // R2 stop while active via command write
        write_byte(3'd0, 8'h09);
        check("R2", "run on", {31'h0, eng_run}, 32'h1);
        write_byte(3'd0, 8'h08);
        check("R2", "run off", {31'h0, eng_run}, 32'h0);
        read_chk("R2", 3'd2, 8'h00);

        // R1 reset in mid-use clears everything
        write_byte(3'd0, 8'h09);
        write_byte(3'd2, 8'h60);
        @(negedge clk);
        eng_intr = 1'b1;
        @(negedge clk);
        eng_intr = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) read_chk("R1", 3'(a), 8'h00);
        check("R1", "outputs after reset", {29'h0, irq, eng_run, eng_to_mem}, 32'h0);
        check("R1", "table base after reset", eng_table_base, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule